// File: doc/BRIEF.md
# Per-Class Bandwidth Delay Table

This block keeps one delay setting for each class of service used by a memory bandwidth limiter. A larger delay blocks more of a class's bandwidth. Software reaches the table through a small request/response register port. Each class has its own address in a 64-slot window. A separate association register names the class that is currently running, and the block drives that class's delay on `delay_out` to a throttling engine elsewhere on the chip.

The hardware supports only some delay values, so every value written to the table is snapped to one of them before it is stored. Any value above the maximum delay is first clamped to the maximum. In linear mode the result is then rounded down to a multiple of a step, where the step is 100 minus the maximum delay. In non-linear mode it is rounded down to zero or to a power of two. A read of a table entry returns the stored, snapped value. Requests to addresses that do not exist change nothing, return zero and flag an error.

Top module: `bw_throttle_table`

## Requirements
- R1: After reset every class entry holds 0, the association register holds class 0, and `delay_out` is 0.
- R2: With `linear_mode` = 1, a write stores floor(c / STEP) * STEP. Here c is the written value after clamping, and STEP = 100 - MAX_DELAY (10 for the default MAX_DELAY of 90).
- R3: With `linear_mode` = 0, a write stores 0 when c is 0. Otherwise it stores the largest power of two that is not greater than c.
- R4: A written value greater than MAX_DELAY is clamped to MAX_DELAY before the rounding of R2 or R3 is applied.
- R5: Class n lives at address BASE_ADDR + n (default 0xD50 + n) for n < NUM_CLASSES. The association register is at ASSOC_ADDR (default 0xC8F), and the class number is the whole of `req_wdata`. Reads return the value zero-extended on `rsp_rdata`.
- R6: A read of a class entry returns the snapped value that was stored, not the raw value that was written.
- R7: The following requests leave all state unchanged, return `rsp_rdata` = 0 and assert `rsp_err` in their response cycle:
  - any request to an address in the window at or beyond NUM_CLASSES;
  - any request to any other undecoded address;
  - an association write of a class number at or above NUM_CLASSES.
- R8: Every request accepted in a cycle produces exactly one response: `rsp_valid` is high in the following cycle and low when no request was made.
- R9: `delay_out` equals the entry of the associated class. It changes right after the clock edge that captures a write to the association register or to the selected entry, and it does not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| linear_mode | input | 1 | Static delay granularity select: 1 linear, 0 power of two |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W (12) | Register address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W (8) | Read data, zero on writes and errors |
| rsp_err | output | 1 | Previous request hit no register or carried a bad class |
| delay_out | output | DELAY_W (7) | Delay of the associated class |

## Verification
The assertions assume three things about the inputs:
- `linear_mode` holds still outside reset, since entries stored under one granularity are not re-snapped when it changes;
- each request is a single-cycle pulse with its address and data valid in that cycle;
- the class-number field of an association write is taken whole, so oversized values must be reported, not truncated.

The bench keeps to these assumptions. It changes mode only while reset is asserted and drives every request for exactly one cycle, away from the sampling edge. It then sweeps all 256 write values across the classes in both modes, and covers every unimplemented window slot and every class association.

// File: rtl/bwt_pkg.sv
`timescale 1ns/1ps
package bwt_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_ENTRY = 2'd1,
      ACC_ASSOC = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/bwt_addr_decode.sv
`timescale 1ns/1ps
module bwt_addr_decode
   import bwt_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          IDX_W       = 6,
   parameter int          NUM_CLASSES = 8,
   parameter logic [11:0] BASE_ADDR   = 12'hD50,
   parameter logic [11:0] ASSOC_ADDR  = 12'hC8F
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] BASE_L  = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] ASSOC_L = ADDR_W'(ASSOC_ADDR);

   logic [ADDR_W-1:0] off;
   assign off = addr - BASE_L;
   assign idx = off[IDX_W-1:0];

   always_comb begin
      kind = ACC_NONE;
      if ((addr >= BASE_L) && (off < ADDR_W'(NUM_CLASSES)))
         kind = ACC_ENTRY;
      else if (addr == ASSOC_L)
         kind = ACC_ASSOC;
   end
endmodule

// File: rtl/bwt_quantizer.sv
`timescale 1ns/1ps
module bwt_quantizer #(
   parameter int DATA_W    = 8,
   parameter int DELAY_W   = 7,
   parameter int MAX_DELAY = 90
) (
   input  logic               linear_mode,
   input  logic [DATA_W-1:0]  raw,
   output logic [DELAY_W-1:0] snapped
);
   localparam int STEP = 100 - MAX_DELAY;

   logic [DELAY_W-1:0] clip;
   logic [DELAY_W-1:0] lin_q;
   logic [DELAY_W-1:0] pow_q;

   assign clip = (raw > DATA_W'(MAX_DELAY)) ? DELAY_W'(MAX_DELAY) : raw[DELAY_W-1:0];

   generate
      if (STEP == 1) begin : g_lin_unit
         assign lin_q = clip;
      end else begin : g_lin_step
         assign lin_q = DELAY_W'((32'(clip) / STEP) * STEP);
      end
   endgenerate

   always_comb begin
      logic seen;
      seen  = 1'b0;
      pow_q = '0;
      for (int i = DELAY_W - 1; i >= 0; i--) begin
         if (clip[i] && !seen) begin
            pow_q[i] = 1'b1;
            seen     = 1'b1;
         end
      end
   end

   assign snapped = linear_mode ? lin_q : pow_q;
endmodule

// File: rtl/bwt_entry_bank.sv
`timescale 1ns/1ps
module bwt_entry_bank #(
   parameter int NUM_CLASSES = 8,
   parameter int DELAY_W     = 7,
   parameter int IDX_W       = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [DELAY_W-1:0] wr_val,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DELAY_W-1:0] rd_val,
   input  logic [IDX_W-1:0]   sel_idx,
   output logic [DELAY_W-1:0] sel_val
);
   logic [NUM_CLASSES*DELAY_W-1:0] flat;

   generate
      for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_ent
         logic [DELAY_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               q <= wr_val;
         end
         assign flat[g*DELAY_W +: DELAY_W] = q;
      end
   endgenerate

   always_comb begin
      rd_val  = '0;
      sel_val = '0;
      for (int i = 0; i < NUM_CLASSES; i++) begin
         if (rd_idx == IDX_W'(i))
            rd_val = flat[i*DELAY_W +: DELAY_W];
         if (sel_idx == IDX_W'(i))
            sel_val = flat[i*DELAY_W +: DELAY_W];
      end
   end
endmodule

// File: rtl/bw_throttle_table.sv
`timescale 1ns/1ps
module bw_throttle_table
   import bwt_pkg::*;
#(
   parameter int          NUM_CLASSES = 8,
   parameter int          MAX_DELAY   = 90,
   parameter int          ADDR_W      = 12,
   parameter int          DATA_W      = 8,
   parameter logic [11:0] BASE_ADDR   = 12'hD50,
   parameter logic [11:0] ASSOC_ADDR  = 12'hC8F,
   localparam int         DELAY_W     = $clog2(MAX_DELAY + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               linear_mode,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_err,
   output logic [DELAY_W-1:0] delay_out
);
   localparam int IDX_W = 6;

   generate
      if (NUM_CLASSES < 1 || NUM_CLASSES > (1 << IDX_W)) begin : g_bad_num
         $error("NUM_CLASSES must lie in 1..64");
      end
      if (MAX_DELAY < 1 || MAX_DELAY > 99) begin : g_bad_max
         $error("MAX_DELAY must lie in 1..99");
      end
      if (DATA_W < DELAY_W || DATA_W < IDX_W) begin : g_bad_data
         $error("DATA_W too narrow for delay or class fields");
      end
      if (ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must not exceed 12");
      end
   endgenerate

   acc_kind_e          kind;
   logic [IDX_W-1:0]   idx;
   logic [DELAY_W-1:0] snapped;
   logic [DELAY_W-1:0] rd_val;
   logic [IDX_W-1:0]   assoc_q;
   logic               assoc_bad;
   logic               req_bad;
   logic               ent_we;
   logic [DATA_W-1:0]  rd_mux;

   bwt_addr_decode #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_CLASSES(NUM_CLASSES),
      .BASE_ADDR(BASE_ADDR), .ASSOC_ADDR(ASSOC_ADDR)
   ) u_dec (
      .addr(req_addr), .kind(kind), .idx(idx)
   );

   bwt_quantizer #(
      .DATA_W(DATA_W), .DELAY_W(DELAY_W), .MAX_DELAY(MAX_DELAY)
   ) u_quant (
      .linear_mode(linear_mode), .raw(req_wdata), .snapped(snapped)
   );

   assign ent_we = req_valid && req_write && (kind == ACC_ENTRY);

   bwt_entry_bank #(
      .NUM_CLASSES(NUM_CLASSES), .DELAY_W(DELAY_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ent_we), .wr_idx(idx), .wr_val(snapped),
      .rd_idx(idx), .rd_val(rd_val),
      .sel_idx(assoc_q), .sel_val(delay_out)
   );

   assign assoc_bad = req_write && (req_wdata >= DATA_W'(NUM_CLASSES));
   assign req_bad   = (kind == ACC_NONE) || ((kind == ACC_ASSOC) && assoc_bad);

   always_ff @(posedge clk) begin
      if (!rst_n)
         assoc_q <= '0;
      else if (req_valid && req_write && (kind == ACC_ASSOC) && !assoc_bad)
         assoc_q <= req_wdata[IDX_W-1:0];
   end

   always_comb begin
      rd_mux = '0;
      if (!req_write && !req_bad) begin
         if (kind == ACC_ENTRY)
            rd_mux = DATA_W'(rd_val);
         else if (kind == ACC_ASSOC)
            rd_mux = DATA_W'(assoc_q);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && req_bad;
         rsp_rdata <= req_valid ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/bw_throttle_table_chk.sv
`timescale 1ns/1ps
module bw_throttle_table_chk #(
   parameter int MAX_DELAY = 90,
   parameter int DATA_W    = 8,
   parameter int DELAY_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               linear_mode,
   input logic               req_valid,
   input logic               req_write,
   input logic               rsp_valid,
   input logic [DATA_W-1:0]  rsp_rdata,
   input logic               rsp_err,
   input logic [DELAY_W-1:0] delay_out
);
   localparam int STEP = 100 - MAX_DELAY;

   // R2: linear granularity reaches the output
   a_r2_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      linear_mode |-> ((32'(delay_out) % STEP) == 0));

   // R3: non-linear output is zero or a single set bit
   a_r3_pow_two: assert property (@(posedge clk) disable iff (!rst_n)
      !linear_mode |-> ($countones(delay_out) <= 1));

   // R4: clamped at the maximum
   a_r4_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
      32'(delay_out) <= MAX_DELAY);

   // R7: errored responses carry no data
   a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   // R7, R8: an error flag only rides on a response
   a_r8_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

   // R8: a request is answered in the next cycle
   a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R8: no request, no response
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R9: output moves only after a write
   a_r9_stable_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(delay_out));
endmodule

bind bw_throttle_table bw_throttle_table_chk #(
   .MAX_DELAY(MAX_DELAY), .DATA_W(DATA_W), .DELAY_W(DELAY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
   .req_valid(req_valid), .req_write(req_write),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .delay_out(delay_out)
);

// File: tb/sim_bw_throttle_table.sv
`timescale 1ns/1ps
module sim_bw_throttle_table;
   localparam int NUM   = 8;
   localparam int MAXD  = 90;
   localparam int STEP  = 100 - MAXD;
   localparam int BASE  = 'hD50;
   localparam int ASSOC = 'hC8F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        linear_mode = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic        rsp_err;
   logic [6:0]  delay_out;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   int shadow [NUM];
   int cur_cls;

   always #4 clk = ~clk;

   bw_throttle_table u0 (
      .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .delay_out(delay_out)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_total++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int exp_q(input int v, input bit lin);
      int c;
      int p;
      c = (v > MAXD) ? MAXD : v;
      if (lin) return (c / STEP) * STEP;
      p = 0;
      for (int b = 0; b < 8; b++)
         if ((1 << b) <= c) p = 1 << b;
      return p;
   endfunction

   task automatic xact(input bit w, input int a, input int d,
                       output int rd, output bit er);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = 12'(a);
      req_wdata = 8'(d);
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      rd = int'(rsp_rdata);
      er = rsp_err;
      chk("R8 rsp_valid after request", int'(rsp_valid), 1);
   endtask

   task automatic do_reset(input bit lin);
      @(negedge clk);
      rst_n = 1'b0;
      linear_mode = lin;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NUM; i++) shadow[i] = 0;
      cur_cls = 0;
   endtask

   task automatic run_mode(input bit lin);
      int rd;
      bit er;
      int old;
      do_reset(lin);
      chk("R1 delay_out after reset", int'(delay_out), 0);
      chk("R8 idle rsp_valid", int'(rsp_valid), 0);
      for (int i = 0; i < NUM; i++) begin
         xact(1'b0, BASE + i, 0, rd, er);
         chk("R1 entry zero after reset", rd, 0);
      end
      xact(1'b0, ASSOC, 0, rd, er);
      chk("R1 assoc zero after reset", rd, 0);

      // full sweep of write values, R2/R3/R4/R6
      for (int v = 0; v < 256; v++) begin
         int c;
         c = v % NUM;
         xact(1'b1, BASE + c, v, rd, er);
         chk("R5 entry write no error", int'(er), 0);
         shadow[c] = exp_q(v, lin);
         xact(1'b0, BASE + c, 0, rd, er);
         if (v > MAXD)
            chk("R4 clamp then snap", rd, shadow[c]);
         else if (lin)
            chk("R2 linear snap readback R6", rd, shadow[c]);
         else
            chk("R3 pow2 snap readback R6", rd, shadow[c]);
      end

      // distinct contents, address map R5
      for (int i = 0; i < NUM; i++) begin
         xact(1'b1, BASE + i, 11 * i + 5, rd, er);
         shadow[i] = exp_q(11 * i + 5, lin);
      end
      for (int i = 0; i < NUM; i++) begin
         xact(1'b0, BASE + i, 0, rd, er);
         chk("R5 per-class address", rd, shadow[i]);
      end

      // association and delay_out tracking R9
      for (int i = 0; i < NUM; i++) begin
         xact(1'b1, ASSOC, i, rd, er);
         cur_cls = i;
         chk("R9 delay_out after assoc write", int'(delay_out), shadow[i]);
         xact(1'b0, ASSOC, 0, rd, er);
         chk("R5 assoc readback", rd, i);
         xact(1'b1, BASE + ((i + 1) % NUM), 77, rd, er);
         shadow[(i + 1) % NUM] = exp_q(77, lin);
         chk("R9 delay_out unaffected by other entry", int'(delay_out), shadow[i]);
         xact(1'b1, BASE + i, 40 + i, rd, er);
         shadow[i] = exp_q(40 + i, lin);
         chk("R9 delay_out after selected entry write", int'(delay_out), shadow[i]);
      end

      // unimplemented window slots R7
      for (int a = NUM; a < 64; a++) begin
         xact(1'b1, BASE + a, 255, rd, er);
         chk("R7 write beyond classes err", int'(er), 1);
         chk("R7 write beyond classes data", rd, 0);
         xact(1'b0, BASE + a, 0, rd, er);
         chk("R7 read beyond classes err", int'(er), 1);
         chk("R7 read beyond classes data", rd, 0);
      end
      xact(1'b0, 0, 0, rd, er);
      chk("R7 undecoded read err", int'(er), 1);
      xact(1'b1, BASE - 1, 200, rd, er);
      chk("R7 undecoded write err", int'(er), 1);
      for (int i = 0; i < NUM; i++) begin
         xact(1'b0, BASE + i, 0, rd, er);
         chk("R7 entries untouched", rd, shadow[i]);
      end

      // bad class number on association R7
      old = int'(delay_out);
      xact(1'b1, ASSOC, NUM + 1, rd, er);
      chk("R7 bad class err", int'(er), 1);
      chk("R7 bad class delay_out kept", int'(delay_out), old);
      xact(1'b0, ASSOC, 0, rd, er);
      chk("R7 bad class assoc kept", rd, cur_cls);
      chk("R7 good read no err", int'(er), 0);
      @(negedge clk);
      chk("R8 no response when idle", int'(rsp_valid), 0);
   endtask

   initial begin
      run_mode(1'b1);
      run_mode(1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog expired got 0 expected 1");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule